// File: doc/BRIEF.md
# Flash Command Source Arbiter

This block decides which of four requesters may start a command sequence on a single flash sequence engine: bus reads, bus writes, software-issued (IP) commands, and a previously suspended command that wants to resume. Only one source holds the grant at a time. The grant lasts until the engine reports completion or until the execution watchdog aborts the sequence.

Three watchdogs scale a small configured value by 2^SCALE_LOG2 clock cycles (1024 by default). The first limits how long an IP request may wait for a grant. The second does the same for bus reads and writes. The third limits how long a granted sequence may run. A suspended command may resume only after the bus has been idle for a configured number of cycles. Sticky write-one-to-clear flags record grant timeouts, execution timeouts and IP completion, and an interrupt output combines the flags with their enable mask.

The controller is a three-state machine:
- ST_IDLE moves to ST_RUN on a grant.
- ST_RUN moves back to ST_IDLE on engine done, or to ST_ABORT on execution timeout.
- ST_ABORT returns to ST_IDLE once the engine reports idle.

Top module: `seq_source_arbiter`

## Requirements
- R1: The granted source code on `gnt_src` is 0 for bus read, 1 for bus write, 2 for IP command and 3 for suspended command. `grant` is one-hot, with bit number equal to that code.
- R2: Among sources requesting while the arbiter is idle, IP wins over bus write, and bus write wins over bus read. The grant is visible one clock after the request is seen in ST_IDLE.
- R3: At most one grant bit is set at a time. A grant stays set while the engine runs and is released in the clock after `eng_done`. After reset, `grant`, `eng_abort`, `req_drop`, `flags` and `irq` are all zero.
- R4: An IP request that stays ungranted for `cfg_ip_grant_to`·2^SCALE_LOG2 cycles sets flag bit 0 and pulses `req_drop` bit 2. The request is then ignored until it deasserts.
- R5: A bus read or bus write request that stays ungranted for `cfg_ahb_grant_to`·2^SCALE_LOG2 cycles sets flag bit 1 and pulses `req_drop` bit 0 (read) or bit 1 (write). The request is then ignored until it deasserts.
- R6: A sequence still granted after `cfg_seq_to`·2^SCALE_LOG2 cycles without `eng_done` causes the following in the next clock: `eng_abort` is asserted, `grant` is released and flag bit 2 is set. `eng_abort` drops once `eng_idle` is seen.
- R7: `bus_idle` is high only when the arbiter is in ST_IDLE and `eng_idle` is high.
- R8: A suspended request is eligible only after `bus_idle` has held for `cfg_resume_wait` cycles. Before that point a bus read wins. Once eligible, it outranks a bus read.
- R9: Completion (`eng_done`) of a sequence granted to the IP source sets flag bit 3.
- R10: Flags are sticky. A one in `flag_clr` clears that bit only. A new event in the same cycle wins over the clear. `irq` is the OR of `flags & irq_en`.
- R11: A configured timeout value of zero disables that watchdog, so a request may wait, or a sequence may run, for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Bus read sequence request |
| wr_req | input | 1 | Bus write sequence request |
| ip_req | input | 1 | IP command sequence request |
| sus_req | input | 1 | Suspended command resume request |
| grant | output | 4 | One-hot grant, bit index = source code |
| gnt_src | output | 2 | Code of the granted source (valid while grant is nonzero) |
| req_drop | output | 4 | One-cycle pulse: request dropped on grant timeout |
| eng_done | input | 1 | Engine finished the granted sequence |
| eng_idle | input | 1 | Engine is idle |
| eng_abort | output | 1 | Abort request to the engine |
| bus_idle | output | 1 | Arbiter and engine both idle |
| cfg_ip_grant_to | input | GTO_W | IP grant timeout in scaled units, 0 = off |
| cfg_ahb_grant_to | input | GTO_W | Bus grant timeout in scaled units, 0 = off |
| cfg_seq_to | input | SEQ_W | Execution timeout in scaled units, 0 = off |
| cfg_resume_wait | input | RES_W | Idle cycles required before a resume |
| irq_en | input | 4 | Interrupt enable per flag |
| flag_clr | input | 4 | Write-one-to-clear strobe per flag |
| flags | output | 4 | Sticky flags: 0 IP grant timeout, 1 bus grant timeout, 2 execution timeout, 3 IP done |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the arbiter with SCALE_LOG2 = 2, so one timeout unit is four clocks. This lets the exact expiry cycle of every watchdog be checked within a few tens of cycles, rather than thousands. The timeout and resume-wait widths stay at their defaults. Small values such as 1, 2, 3 and 5 therefore exercise the expiry edge on both sides, and zero exercises the disabled case. Random request mixes probe the priority order against a bench model.

// File: rtl/seqarb_pkg.sv
package seqarb_pkg;

    typedef enum logic [1:0] {
        SRC_RD  = 2'd0,
        SRC_WR  = 2'd1,
        SRC_IP  = 2'd2,
        SRC_SUS = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ABORT = 2'd2
    } arb_state_e;

    localparam int NSRC         = 4;
    localparam int NWAIT        = 3;
    localparam int NFLAG        = 4;
    localparam int FLAG_IP_GTO  = 0;
    localparam int FLAG_BUS_GTO = 1;
    localparam int FLAG_SEQ_TO  = 2;
    localparam int FLAG_IP_DONE = 3;

endpackage

// File: rtl/arb_timeout_counter.sv
module arb_timeout_counter #(
    parameter int CFG_W      = 8,
    parameter int SCALE_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CFG_W-1:0] limit,
    output logic             expired
);
    localparam int CNT_W = CFG_W + SCALE_LOG2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // last cycle index of the window: limit * 2^SCALE_LOG2 - 1
    assign last    = (CNT_W'(limit) << SCALE_LOG2) - CNT_W'(1);
    assign expired = run && (limit != '0) && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/arb_priority_pick.sv
module arb_priority_pick
    import seqarb_pkg::*;
(
    input  logic rd,
    input  logic wr,
    input  logic ip,
    input  logic sus_ok,
    output logic any,
    output src_e pick
);
    always_comb begin
        any  = ip | wr | sus_ok | rd;
        pick = SRC_RD;
        if (ip) begin
            pick = SRC_IP;
        end else if (wr) begin
            pick = SRC_WR;
        end else if (sus_ok) begin
            pick = SRC_SUS;
        end
    end
endmodule

// File: rtl/arb_resume_gate.sv
module arb_resume_gate #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_idle,
    input  logic [RES_W-1:0] wait_cfg,
    output logic             elapsed
);
    logic [RES_W-1:0] idle_cnt;

    assign elapsed = bus_idle && (idle_cnt >= wait_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!bus_idle) begin
            idle_cnt <= '0;
        end else if (idle_cnt != '1) begin
            idle_cnt <= idle_cnt + RES_W'(1);
        end
    end
endmodule

// File: rtl/seq_source_arbiter.sv
module seq_source_arbiter
    import seqarb_pkg::*;
#(
    parameter int GTO_W      = 8,
    parameter int SEQ_W      = 16,
    parameter int RES_W      = 8,
    parameter int SCALE_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             ip_req,
    input  logic             sus_req,
    output logic [3:0]       grant,
    output logic [1:0]       gnt_src,
    output logic [3:0]       req_drop,
    input  logic             eng_done,
    input  logic             eng_idle,
    output logic             eng_abort,
    output logic             bus_idle,
    input  logic [GTO_W-1:0] cfg_ip_grant_to,
    input  logic [GTO_W-1:0] cfg_ahb_grant_to,
    input  logic [SEQ_W-1:0] cfg_seq_to,
    input  logic [RES_W-1:0] cfg_resume_wait,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       flag_clr,
    output logic [3:0]       flags,
    output logic             irq
);
    arb_state_e       state, state_nxt;
    src_e             cur_src;
    src_e             pick;
    logic             pick_any;
    logic             grant_now;
    logic             arb_idle;
    logic             resume_ok;
    logic             seq_exp;
    logic [NSRC-1:0]  src_req;
    logic [NWAIT-1:0] blocked;
    logic [NWAIT-1:0] eff_req;
    logic [NWAIT-1:0] gto;
    logic [NFLAG-1:0] flag_set;

    assign src_req = {sus_req, ip_req, wr_req, rd_req};

    // ---------------- source selection ----------------
    arb_priority_pick u_pick (
        .rd     (eff_req[SRC_RD]),
        .wr     (eff_req[SRC_WR]),
        .ip     (eff_req[SRC_IP]),
        .sus_ok (sus_req && resume_ok),
        .any    (pick_any),
        .pick   (pick)
    );

    assign grant_now = (state == ST_IDLE) && pick_any;

    arb_resume_gate #(.RES_W(RES_W)) u_resume (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_idle (bus_idle),
        .wait_cfg (cfg_resume_wait),
        .elapsed  (resume_ok)
    );

    // ---------------- grant-wait watchdogs ----------------
    for (genvar g = 0; g < NWAIT; g++) begin : g_wait
        logic [GTO_W-1:0] lim;
        logic             waiting;

        if (g == int'(SRC_IP)) begin : g_ip_lim
            assign lim = cfg_ip_grant_to;
        end else begin : g_bus_lim
            assign lim = cfg_ahb_grant_to;
        end

        assign eff_req[g] = src_req[g] && !blocked[g];
        assign waiting    = eff_req[g]
                         && !((state == ST_RUN) && (cur_src == src_e'(g)))
                         && !(grant_now && (pick == src_e'(g)));

        arb_timeout_counter #(.CFG_W(GTO_W), .SCALE_LOG2(SCALE_LOG2)) u_wdog (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (waiting),
            .limit   (lim),
            .expired (gto[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blocked[g] <= 1'b0;
            end else if (gto[g]) begin
                blocked[g] <= 1'b1;
            end else if (!src_req[g]) begin
                blocked[g] <= 1'b0;
            end
        end
    end

    // ---------------- execution watchdog ----------------
    arb_timeout_counter #(.CFG_W(SEQ_W), .SCALE_LOG2(SCALE_LOG2)) u_seq_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((state == ST_RUN) && !eng_done),
        .limit   (cfg_seq_to),
        .expired (seq_exp)
    );

    // ---------------- state machine ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (grant_now) state_nxt = ST_RUN;
            ST_RUN: begin
                if (eng_done)     state_nxt = ST_IDLE;
                else if (seq_exp) state_nxt = ST_ABORT;
            end
            ST_ABORT: if (eng_idle) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_src <= SRC_RD;
        end else begin
            state <= state_nxt;
            if (grant_now) begin
                cur_src <= pick;
            end
        end
    end

    always_comb begin
        grant     = '0;
        eng_abort = 1'b0;
        arb_idle  = 1'b0;
        unique case (state)
            ST_IDLE:  arb_idle  = 1'b1;
            ST_RUN:   grant     = 4'b0001 << cur_src;
            ST_ABORT: eng_abort = 1'b1;
            default:  arb_idle  = 1'b0;
        endcase
    end

    assign gnt_src  = cur_src;
    assign bus_idle = arb_idle && eng_idle;

    // ---------------- flags and interrupt ----------------
    always_comb begin
        flag_set               = '0;
        flag_set[FLAG_IP_GTO]  = gto[SRC_IP];
        flag_set[FLAG_BUS_GTO] = gto[SRC_RD] | gto[SRC_WR];
        flag_set[FLAG_SEQ_TO]  = seq_exp && (state == ST_RUN);
        flag_set[FLAG_IP_DONE] = (state == ST_RUN) && (cur_src == SRC_IP) && eng_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags    <= '0;
            req_drop <= '0;
        end else begin
            flags    <= (flags & ~flag_clr) | flag_set;
            req_drop <= {1'b0, gto};
        end
    end

    assign irq = |(flags & irq_en);

endmodule

// File: rtl/seq_source_arbiter_chk.sv
module seq_source_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] grant,
    input logic [1:0] gnt_src,
    input logic [3:0] req_drop,
    input logic       eng_done,
    input logic       eng_idle,
    input logic       eng_abort,
    input logic       bus_idle,
    input logic [3:0] flag_clr,
    input logic [3:0] flags
);
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 4'b0) |-> grant[gnt_src]);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != 4'b0) && eng_done) |=> (grant == 4'b0));

    p_abort_nogrant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (grant == 4'b0));

    p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_abort) |-> flags[2]);

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> (eng_idle && (grant == 4'b0) && !eng_abort));

    p_drop_ip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_drop[2] |-> flags[0]);

    p_drop_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_drop[1:0] != 2'b0) |-> flags[1]);

    p_ipdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[2] && eng_done) |=> flags[3]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

bind seq_source_arbiter seq_source_arbiter_chk u_chk (.*);

// File: tb/seq_source_arbiter_test.sv
module seq_source_arbiter_test;
    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       rd_req, wr_req, ip_req, sus_req;
    logic [3:0] grant;
    logic [1:0] gnt_src;
    logic [3:0] req_drop;
    logic       eng_done;
    logic       eng_idle;
    logic       eng_abort;
    logic       bus_idle;
    logic [7:0] cfg_ip_grant_to, cfg_ahb_grant_to, cfg_resume_wait;
    logic [15:0] cfg_seq_to;
    logic [3:0] irq_en, flag_clr, flags;
    logic       irq;

    int checks = 0;
    int errors = 0;

    assign eng_idle = (grant == 4'b0);

    seq_source_arbiter #(.SCALE_LOG2(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .wr_req(wr_req), .ip_req(ip_req), .sus_req(sus_req),
        .grant(grant), .gnt_src(gnt_src), .req_drop(req_drop),
        .eng_done(eng_done), .eng_idle(eng_idle), .eng_abort(eng_abort),
        .bus_idle(bus_idle),
        .cfg_ip_grant_to(cfg_ip_grant_to), .cfg_ahb_grant_to(cfg_ahb_grant_to),
        .cfg_seq_to(cfg_seq_to), .cfg_resume_wait(cfg_resume_wait),
        .irq_en(irq_en), .flag_clr(flag_clr), .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // finish the running sequence; afterwards the arbiter is in ST_IDLE
    task automatic end_seq();
        eng_done = 1'b1;
        tick(1);
        eng_done = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 4'hF;
        tick(1);
        flag_clr = 4'h0;
    endtask

    function automatic logic [1:0] exp_src(input logic ip, input logic wr);
        if (ip) return 2'd2;
        if (wr) return 2'd1;
        return 2'd0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] pat;
        logic [1:0] e;
        int         hold;

        rst_n = 1'b0;
        {rd_req, wr_req, ip_req, sus_req, eng_done} = '0;
        cfg_ip_grant_to = 0; cfg_ahb_grant_to = 0; cfg_seq_to = 0; cfg_resume_wait = 0;
        irq_en = 0; flag_clr = 0;
        void'($urandom(32'h5EED_0421));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        chk("R3 reset grant", grant, 0);
        chk("R3 reset abort", eng_abort, 0);
        chk("R3 reset drop", req_drop, 0);
        chk("R10 reset flags", flags, 0);
        chk("R10 reset irq", irq, 0);
        chk("R7 reset bus_idle", bus_idle, 1);

        // random request mixes: priority R2, encoding R1, hold/release R3
        for (int i = 0; i < 40; i++) begin
            pat = 3'($urandom_range(1, 7));
            ip_req = pat[2]; wr_req = pat[1]; rd_req = pat[0];
            tick(1);
            e = exp_src(pat[2], pat[1]);
            chk("R2 winner code", gnt_src, e);
            chk("R1 one-hot grant", grant, 4'b0001 << e);
            {ip_req, wr_req, rd_req} = '0;
            hold = $urandom_range(0, 4);
            tick(hold);
            chk("R3 grant held", grant, 4'b0001 << e);
            chk("R7 busy not idle", bus_idle, 0);
            end_seq();
            chk("R3 release after done", grant, 0);
            chk("R9 ip done flag", flags, (e == 2'd2) ? 4'b1000 : 4'b0000);
            clear_flags();
            tick(1);
        end

        // R4: IP grant timeout, limit 2 units = 8 cycles
        cfg_ip_grant_to = 2;
        wr_req = 1; tick(1); wr_req = 0;
        chk("R4 setup write grant", grant, 4'b0010);
        ip_req = 1;
        tick(7);
        chk("R4 flag before limit", flags, 0);
        tick(1);
        chk("R4 flag at limit", flags, 4'b0001);
        chk("R4 drop pulse", req_drop, 4'b0100);
        end_seq();
        tick(3);
        chk("R4 dropped request ignored", grant, 0);
        ip_req = 0; tick(1); ip_req = 1; tick(1);
        chk("R4 re-request granted", grant, 4'b0100);
        ip_req = 0;
        end_seq();
        chk("R9 ip done with sticky R4 flag", flags, 4'b1001);
        clear_flags();
        chk("R10 clear all", flags, 0);

        // R5: bus grant timeout, limit 1 unit = 4 cycles
        cfg_ahb_grant_to = 1;
        ip_req = 1; tick(1); ip_req = 0;
        rd_req = 1;
        tick(3);
        chk("R5 flag before limit", flags, 0);
        tick(1);
        chk("R5 flag at limit", flags, 4'b0010);
        chk("R5 read drop pulse", req_drop, 4'b0001);
        flag_clr = 4'b0001; tick(1); flag_clr = 0;
        chk("R10 clear of unset bit", flags, 4'b0010);
        end_seq();
        chk("R9 ip done", flags, 4'b1010);
        flag_clr = 4'b0010; tick(1); flag_clr = 0;
        chk("R10 clear one bit", flags, 4'b1000);
        rd_req = 0;
        irq_en = 4'b0111; #1;
        chk("R10 irq masked", irq, 0);
        irq_en = 4'b1000; #1;
        chk("R10 irq enabled", irq, 1);
        clear_flags();
        chk("R10 irq after clear", irq, 0);
        irq_en = 0;

        // R11: zero disables watchdogs
        cfg_ip_grant_to = 0; cfg_ahb_grant_to = 0; cfg_seq_to = 0;
        wr_req = 1; tick(1); wr_req = 0;
        ip_req = 1; rd_req = 1;
        tick(60);
        chk("R11 no timeout flags", flags, 0);
        chk("R11 long sequence kept", grant, 4'b0010);
        end_seq();
        tick(1);
        chk("R11 waiting ip granted", grant, 4'b0100);
        ip_req = 0;
        end_seq();
        clear_flags();
        chk("R11 waiting read granted", grant, 4'b0001);
        rd_req = 0;
        end_seq();

        // R6: execution timeout, 3 units = 12 cycles
        cfg_seq_to = 3;
        tick(1);
        rd_req = 1; tick(1); rd_req = 0;
        chk("R6 setup read grant", grant, 4'b0001);
        tick(11);
        chk("R6 still granted", grant, 4'b0001);
        chk("R6 no abort yet", eng_abort, 0);
        tick(1);
        chk("R6 abort", eng_abort, 1);
        chk("R6 grant released", grant, 0);
        chk("R6 flag", flags, 4'b0100);
        tick(1);
        chk("R6 abort ends", eng_abort, 0);
        chk("R7 idle after abort", bus_idle, 1);
        clear_flags();
        cfg_seq_to = 0;

        // R8: resume wait of 5 idle cycles
        cfg_resume_wait = 5;
        wr_req = 1; tick(1); wr_req = 0;
        rd_req = 1; sus_req = 1;
        end_seq();
        chk("R8 idle after done", grant, 0);
        tick(1);
        chk("R8 read before resume", grant, 4'b0001);
        rd_req = 0;
        end_seq();
        tick(5);
        chk("R8 resume still waiting", grant, 0);
        tick(1);
        chk("R8 resume granted", grant, 4'b1000);
        chk("R1 suspended code", gnt_src, 3);
        sus_req = 0;
        end_seq();
        tick(10);
        rd_req = 1; sus_req = 1;
        tick(1);
        chk("R8 resume outranks read", grant, 4'b1000);
        sus_req = 0;
        end_seq();
        tick(1);
        chk("R8 read after resume", grant, 4'b0001);
        rd_req = 0;
        end_seq();
        chk("R9 no ip done flag", flags, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule